// File: doc/BRIEF.md
# Port-Write Receive Controller

This block takes inbound port-write packets from a serial-link message path, screens each packet header, and hands every good packet to a local queue through a valid/ready write handshake. Software controls it through a two-register interface. The control register holds a run bit and an interrupt-enable bit. The status register holds a sticky fault flag, cleared by writing 1, and a busy flag.

When a packet header fails screening, or the queue reports a fault on a write, the controller sets the fault flag, stops, and drops busy. Software can learn of the stop by polling, or through the interrupt output when interrupts are enabled. To resume, software must see the run bit at 0 while the controller is halted, clear the fault, and then set the run bit again. Clearing the fault alone leaves the controller stopped.

Top module: `pw_rx_ctrl`

## Requirements
- R1: After reset the run bit, interrupt enable, fault flag, busy, pkt_ready, q_valid and irq are all 0.
- R2: pkt_ready is 1 only while the controller is idle (no queue write pending, not halted), the run bit is 1 and the fault flag is 0.
- R3: In the cycle after a packet with a good header is accepted, q_valid is 1, q_data equals the accepted payload and busy is 1. q_valid and q_data hold until the cycle in which q_ready is 1. In the cycle after that handshake, q_valid and busy are 0.
- R4: A header is good only when pkt_ftype equals 8 and pkt_tsize equals the configured transport mode (0 = small, 1 = large; default small). The tsize values 2 and 3 are reserved and always bad. An accepted bad header produces no queue write and sets the fault flag in the next cycle.
- R5: A queue handshake with q_fault at 1 sets the fault flag. q_valid and busy are 0 in the next cycle.
- R6: While halted after a fault, busy and pkt_ready stay 0.
- R7: The control register is at address 0, with bit 0 = run and bit 1 = interrupt enable. The status register is at address 1, with bit 0 = fault and bit 1 = busy (read-only). Writing 1 to status bit 0 clears the fault flag. Writing 0 leaves it unchanged. A fault raised in the same cycle as the clear wins.
- R8: irq is 1 exactly when the fault flag and the interrupt enable are both 1. With interrupts disabled, a fault is visible only through the status register.
- R9: A halted controller resumes, with pkt_ready at 1, only after three things have happened: the run bit was 0 at some cycle during the halt, the fault flag is 0, and the run bit is 1. Clearing the fault while the run bit stays 1 keeps it halted.
- R10: Clearing the run bit during a pending queue write lets that write complete, but no new packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data for reg_addr |
| pkt_valid | input | 1 | Inbound packet present |
| pkt_ready | output | 1 | Controller accepts a packet |
| pkt_ftype | input | 4 | Packet format type field |
| pkt_tsize | input | 2 | Packet transport size field |
| pkt_data | input | DATA_W | Packet payload |
| q_valid | output | 1 | Queue write request |
| q_ready | input | 1 | Queue accepts the write |
| q_fault | input | 1 | Queue reports a fault on the write being accepted |
| q_data | output | DATA_W | Payload written to the queue |
| irq | output | 1 | Fault interrupt |

## Verification
The hardest state to reach from the ports is a fault being raised in the same cycle that software writes 1 to clear the flag. In that case the raise must win. The bench reaches it by holding a queue write pending, then driving q_ready with q_fault in the very cycle that it issues the status write. It also leaves the run bit at 1 while clearing the fault, to show that the controller stays halted. Between these directed cases, a seeded random run mixes good and malformed headers, stall lengths and queue faults, with a random choice of recovery order.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_HALT  = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic [3:0] ftype;
        logic [1:0] tsize;
    } pw_hdr_t;

    localparam logic [3:0] FTYPE_PORT_WRITE = 4'd8;
    localparam int         REG_W            = 2;
    localparam logic       ADDR_CTRL        = 1'b0;
    localparam logic       ADDR_STAT        = 1'b1;
    localparam int         CTRL_RUN         = 0;
    localparam int         CTRL_IE          = 1;
    localparam int         STAT_FAULT       = 0;
    localparam int         STAT_BUSY        = 1;

    // True when the header must be rejected.
    function automatic logic hdr_bad(pw_hdr_t h, logic large_mode);
        return (h.ftype != FTYPE_PORT_WRITE) || h.tsize[1] || (h.tsize[0] != large_mode);
    endfunction

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
    import pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             fault_set,
    input  logic             busy,
    output logic             run,
    output logic             ie,
    output logic             fault,
    output logic [REG_W-1:0] rdata
);

    logic clr_req;
    assign clr_req = wr && (addr == ADDR_STAT) && wdata[STAT_FAULT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            ie    <= 1'b0;
            fault <= 1'b0;
        end else begin
            if (wr && addr == ADDR_CTRL) begin
                run <= wdata[CTRL_RUN];
                ie  <= wdata[CTRL_IE];
            end
            if (fault_set)
                fault <= 1'b1;
            else if (clr_req)
                fault <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[CTRL_RUN] = run;
            rdata[CTRL_IE]  = ie;
        end else begin
            rdata[STAT_FAULT] = fault;
            rdata[STAT_BUSY]  = busy;
        end
    end

    // R7: write-one clears the flag when no new fault arrives
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !fault_set) |=> !fault);
    // R7: writing zero to the fault bit keeps it
    a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (fault && wr && addr == ADDR_STAT && !wdata[STAT_FAULT]) |=> fault);
    // R7: a fault raised together with a clear wins
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        fault_set |=> fault);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit LARGE_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              fault,
    input  logic              pkt_valid,
    input  pw_hdr_t           pkt_hdr,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              q_ready,
    input  logic              q_fault,
    output logic              pkt_ready,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data,
    output logic              busy,
    output logic              fault_set
);

    pw_state_e         state, state_n;
    logic [DATA_W-1:0] data_q;
    logic              seen_off;
    logic              accept, bad, done;

    assign pkt_ready = (state == ST_IDLE) && run && !fault;
    assign accept    = pkt_valid && pkt_ready;
    assign bad       = hdr_bad(pkt_hdr, LARGE_MODE);
    assign done      = (state == ST_WRITE) && q_ready;
    assign fault_set = (accept && bad) || (done && q_fault);

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (accept) state_n = bad ? ST_HALT : ST_WRITE;
            ST_WRITE: if (done)   state_n = q_fault ? ST_HALT : ST_IDLE;
            ST_HALT:  if (seen_off && run && !fault) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            data_q   <= '0;
            seen_off <= 1'b0;
        end else begin
            state <= state_n;
            if (accept && !bad)
                data_q <= pkt_data;
            if (state != ST_HALT)
                seen_off <= 1'b0;
            else if (!run)
                seen_off <= 1'b1;
        end
    end

    assign q_valid = (state == ST_WRITE);
    assign q_data  = data_q;
    assign busy    = (state == ST_WRITE);

    // R3: a stalled write holds its request and payload
    a_r3_hold_write: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_ready) |=> (q_valid && $stable(q_data)));
    // R6: a fault leaves the controller quiet
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        fault_set |=> (!busy && !pkt_ready));
    // R9: no resume before a disable has been seen
    a_r9_need_off: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !seen_off) |=> !pkt_ready);
    // R10: disabling does not abort a pending write
    a_r10_write_survives: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_ready && !run) |=> q_valid);

endmodule

// File: rtl/pw_rx_ctrl.sv
module pw_rx_ctrl
    import pwr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit LARGE_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [1:0]        reg_wdata,
    output logic [1:0]        reg_rdata,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [3:0]        pkt_ftype,
    input  logic [1:0]        pkt_tsize,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              q_valid,
    input  logic              q_ready,
    input  logic              q_fault,
    output logic [DATA_W-1:0] q_data,
    output logic              irq
);

    logic    run, ie, fault, busy, fault_set;
    pw_hdr_t hdr;

    assign hdr.ftype = pkt_ftype;
    assign hdr.tsize = pkt_tsize;

    pwr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .fault_set (fault_set),
        .busy      (busy),
        .run       (run),
        .ie        (ie),
        .fault     (fault),
        .rdata     (reg_rdata)
    );

    pwr_fsm #(.DATA_W(DATA_W), .LARGE_MODE(LARGE_MODE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fault     (fault),
        .pkt_valid (pkt_valid),
        .pkt_hdr   (hdr),
        .pkt_data  (pkt_data),
        .q_ready   (q_ready),
        .q_fault   (q_fault),
        .pkt_ready (pkt_ready),
        .q_valid   (q_valid),
        .q_data    (q_data),
        .busy      (busy),
        .fault_set (fault_set)
    );

    assign irq = fault && ie;

    // R2: packets are taken only while running, clean and idle
    a_r2_ready_gated: assert property (@(posedge clk) disable iff (rst)
        pkt_ready |-> (!busy && !irq && !q_valid));
    // R5: a faulted queue handshake ends the write
    a_r5_fault_stops: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready && q_fault) |=> (!q_valid && reg_rdata != 2'b10));
    // R8: the interrupt never rises while interrupts are off
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ie);

endmodule

// File: tb/pw_rx_ctrl_test.sv
`timescale 1ns/1ps
module pw_rx_ctrl_test;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_addr = 1'b0;
    logic [1:0]    reg_wdata = '0, reg_rdata;
    logic          pkt_valid = 1'b0, pkt_ready;
    logic [3:0]    pkt_ftype = 4'd8;
    logic [1:0]    pkt_tsize = 2'd0;
    logic [DW-1:0] pkt_data = '0, q_data;
    logic          q_valid, q_ready = 1'b0, q_fault = 1'b0, irq;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    bit ie_now = 1'b0;

    always #4 clk = ~clk;

    pw_rx_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_ftype(pkt_ftype), .pkt_tsize(pkt_tsize),
        .pkt_data(pkt_data), .q_valid(q_valid), .q_ready(q_ready),
        .q_fault(q_fault), .q_data(q_data), .irq(irq)
    );

    function automatic bit exp_bad(logic [3:0] ft, logic [1:0] ts);
        return (ft != 4'd8) || (ts != 2'd0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic reg_write(input logic a, input logic [1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Sends one packet starting at a negedge; returns at a negedge.
    task automatic send_pkt(input logic [3:0] ft, input logic [1:0] ts,
                            input logic [DW-1:0] d, input int stall, input bit qf);
        logic [1:0] st;
        bit bad;
        bad = exp_bad(ft, ts);
        chk(pkt_ready == 1'b1, "R2", "ready before send", pkt_ready, 1);
        pkt_valid = 1'b1; pkt_ftype = ft; pkt_tsize = ts; pkt_data = d;
        @(negedge clk);
        pkt_valid = 1'b0;
        reg_read(1'b1, st);
        if (bad) begin
            chk(q_valid == 1'b0, "R4", "no write on bad header", q_valid, 0);
            chk(st == 2'b01, "R4", "status after bad header", st, 2'b01);
            chk(pkt_ready == 1'b0, "R6", "ready after fault", pkt_ready, 0);
            chk(irq == ie_now, "R8", "irq after fault", irq, ie_now);
            return;
        end
        chk(q_valid && q_data == d, "R3", "queue payload", q_data, d);
        chk(st == 2'b10, "R3", "busy during write", st, 2'b10);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(q_valid && q_data == d, "R3", "hold while stalled", q_data, d);
        end
        q_ready = 1'b1; q_fault = qf;
        @(negedge clk);
        q_ready = 1'b0; q_fault = 1'b0;
        reg_read(1'b1, st);
        chk(q_valid == 1'b0, "R3", "write ends", q_valid, 0);
        chk(st == {1'b0, qf}, qf ? "R5" : "R3", "status after write", st, {1'b0, qf});
        if (qf) chk(irq == ie_now, "R8", "irq after queue fault", irq, ie_now);
    endtask

    task automatic recover(input bit clear_first);
        if (clear_first) begin
            reg_write(1'b1, 2'b01);
            @(negedge clk);
            chk(pkt_ready == 1'b0, "R9", "still halted with run kept", pkt_ready, 0);
            reg_write(1'b0, {ie_now, 1'b0});
            reg_write(1'b0, {ie_now, 1'b1});
        end else begin
            reg_write(1'b0, {ie_now, 1'b0});
            reg_write(1'b1, 2'b01);
            reg_write(1'b0, {ie_now, 1'b1});
        end
        @(negedge clk);
        chk(pkt_ready == 1'b1, "R9", "resumed", pkt_ready, 1);
        chk(irq == 1'b0, "R8", "irq after clear", irq, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [1:0] st;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!pkt_ready && !q_valid && !irq, "R1", "outputs at reset",
            {pkt_ready, q_valid, irq}, 0);
        reg_read(1'b0, st); chk(st == 2'b00, "R1", "control at reset", st, 0);
        reg_read(1'b1, st); chk(st == 2'b00, "R1", "status at reset", st, 0);

        reg_write(1'b0, 2'b01);
        chk(pkt_ready == 1'b1, "R2", "ready once running", pkt_ready, 1);

        send_pkt(4'd8, 2'd0, 32'hCAFE0001, 2, 1'b0);   // R3 good packet
        send_pkt(4'd8, 2'd0, 32'h00000002, 0, 1'b0);   // R3 no stall

        // R4 wrong type, polling mode (R8 irq stays low)
        send_pkt(4'd5, 2'd0, 32'h1, 0, 1'b0);
        reg_write(1'b1, 2'b00);                        // R7 zero write
        reg_read(1'b1, st); chk(st == 2'b01, "R7", "zero write keeps fault", st, 2'b01);
        recover(1'b1);

        // R4 reserved size, then large size in small mode, with interrupts on
        ie_now = 1'b1; reg_write(1'b0, 2'b11);
        send_pkt(4'd8, 2'd2, 32'h2, 0, 1'b0);
        recover(1'b0);
        send_pkt(4'd8, 2'd1, 32'h3, 0, 1'b0);
        recover(1'b1);

        // R10 disable while a write is pending
        pkt_valid = 1'b1; pkt_ftype = 4'd8; pkt_tsize = 2'd0; pkt_data = 32'hA5A5;
        @(negedge clk);
        pkt_valid = 1'b0;
        reg_write(1'b0, 2'b10);
        chk(q_valid && pkt_ready == 1'b0, "R10", "write pending, intake off",
            {q_valid, pkt_ready}, 2'b10);
        q_ready = 1'b1; @(negedge clk); q_ready = 1'b0;
        reg_read(1'b1, st);
        chk(st == 2'b00 && !pkt_ready, "R10", "write done, still idle off", st, 0);
        reg_write(1'b0, 2'b11);

        // R7 fault raised in the same cycle as a clear: raise wins
        pkt_valid = 1'b1; pkt_data = 32'h77;
        @(negedge clk);
        pkt_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 2'b01;
        q_ready = 1'b1; q_fault = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; q_ready = 1'b0; q_fault = 1'b0;
        reg_read(1'b1, st); chk(st == 2'b01, "R7", "raise beats clear", st, 2'b01);
        chk(irq == 1'b1, "R8", "irq with ie", irq, 1);
        recover(1'b0);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [3:0] ft;
            logic [1:0] ts;
            bit qf;
            ft = ($urandom % 8 == 0) ? 4'($urandom) : 4'd8;
            ts = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
            qf = ($urandom % 16 == 0);
            send_pkt(ft, ts, $urandom, $urandom % 4, qf);
            if (exp_bad(ft, ts) || qf) begin
                ie_now = $urandom % 2;
                recover($urandom % 2);
            end
        end
        summary();
    end

endmodule